// File: doc/BRIEF.md
# Bit Sync Peak and Early/Late Sampler

This block sits behind a spreading-code correlator whose magnitude output arrives at two samples per chip. A symbol spans eleven chips, so each symbol is seen as a window of 22 magnitude samples. For each window the block finds the sample with the largest magnitude and reports it as the on-time sample. It also reports the samples on either side of the peak as the early and late values, which a timing loop outside this block uses for tracking. The index of the peak within the window is reported as well.

The on-time amplitudes are summed over a block of symbols to give a bit sync amplitude measure. The block is 16 symbols long while acquiring and 64 symbols long in data mode. A one-cycle done pulse marks each finished block and presents its sum. The sum for the next block starts again from zero.

Top module: `bitsync_sampler`

## Requirements
- R1: Every 22 accepted samples form one symbol window. A one-cycle `sym_valid` strobe follows the cycle in which the 22nd sample is accepted, and `sym_valid` stays low at all other times.
- R2: At the strobe, `ontime` holds the largest magnitude in the window. `peak_idx` holds that sample's position, counted from 0 for the first sample of the window up to 21 for the last.
- R3: When several samples share the largest magnitude, the earliest of them is the peak.
- R4: `early` is the sample at position peak-1 and `late` is the sample at position peak+1. Both wrap around the window: a peak at 0 gives early from position 21, and a peak at 21 gives late from position 0.
- R5: A cycle with `in_valid` low is ignored. Its `in_mag` value reaches no window and does not advance the sample position.
- R6: The block length is 16 symbols when `data_mode` is 0 and 64 symbols when it is 1. `data_mode` is read when the first symbol of a block completes, so a change in the middle of a block takes effect from the next block.
- R7: `blk_done` pulses in the same cycle as the `sym_valid` strobe of a block's last symbol. At that pulse, `blk_sum` equals the sum of the `ontime` values of all symbols in the block. The next block sums from zero.
- R8: After reset, `sym_valid`, `blk_done`, `ontime`, `early`, `late`, `peak_idx` and `blk_sum` are zero. The next accepted sample is position 0 of a window and the first symbol of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The correlator magnitude sample is present this cycle |
| in_mag | input | MAG_W | Correlator magnitude sample |
| data_mode | input | 1 | 0 selects 16-symbol blocks, 1 selects 64-symbol blocks |
| sym_valid | output | 1 | Per-symbol strobe |
| peak_idx | output | $clog2(SPS) | Position of the on-time sample in the window |
| ontime | output | MAG_W | On-time (peak) magnitude |
| early | output | MAG_W | Sample before the peak, wrapping |
| late | output | MAG_W | Sample after the peak, wrapping |
| blk_done | output | 1 | Block-complete pulse |
| blk_sum | output | MAG_W+$clog2(DATA_SYMS) | Sum of on-time magnitudes over the finished block |

## Verification
The per-symbol strobe and the block-done pulse fall in the same cycle whenever a symbol closes a block. The sum presented at that cycle must already include the on-time value being reported alongside it. The bench provokes this at every 16th or 64th symbol, including a block of all-maximum peaks and blocks whose length setting changes in the middle. It compares `blk_done` and `blk_sum` against a running model at the strobe cycle. It also compares the strobe fields against a peak search over the window, with invalid-cycle gaps carrying large values in between.

// File: rtl/bitsync_sampler.sv
module bitsync_sampler #(
  parameter int MAG_W     = 12,
  parameter int SPS       = 22,
  parameter int ACQ_SYMS  = 16,
  parameter int DATA_SYMS = 64,
  localparam int IDX_W    = $clog2(SPS),
  localparam int CNT_W    = $clog2(DATA_SYMS),
  localparam int SUM_W    = MAG_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [MAG_W-1:0] in_mag,
  input  logic             data_mode,
  output logic             sym_valid,
  output logic [IDX_W-1:0] peak_idx,
  output logic [MAG_W-1:0] ontime,
  output logic [MAG_W-1:0] early,
  output logic [MAG_W-1:0] late,
  output logic             blk_done,
  output logic [SUM_W-1:0] blk_sum
);

  logic [MAG_W-1:0] win_q [SPS];
  logic [MAG_W-1:0] win_c [SPS];
  logic [IDX_W-1:0] pos_q, idx_q, pk_c, e_idx, l_idx;
  logic [MAG_W-1:0] max_q;
  logic [CNT_W-1:0] sym_cnt_q;
  logic [SUM_W-1:0] acc_q;
  logic             long_q, long_c, blk_end, last;

  assign last = in_valid && (pos_q == IDX_W'(SPS-1));

  always_comb begin
    for (int i = 0; i < SPS; i++) win_c[i] = win_q[i];
    win_c[SPS-1] = in_mag;
  end

  assign pk_c    = (in_mag > max_q) ? IDX_W'(SPS-1) : idx_q;
  assign e_idx   = (pk_c == '0) ? IDX_W'(SPS-1) : pk_c - 1'b1;
  assign l_idx   = (pk_c == IDX_W'(SPS-1)) ? '0 : pk_c + 1'b1;
  assign long_c  = (sym_cnt_q == '0) ? data_mode : long_q;
  assign blk_end = long_c ? (sym_cnt_q == CNT_W'(DATA_SYMS-1))
                          : (sym_cnt_q == CNT_W'(ACQ_SYMS-1));

  always_ff @(posedge clk)
    if (in_valid) win_q[pos_q] <= in_mag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      idx_q <= '0;
      max_q <= '0;
    end else if (in_valid) begin
      pos_q <= last ? '0 : pos_q + 1'b1;
      if (pos_q == '0) begin
        max_q <= in_mag;
        idx_q <= '0;
      end else if (in_mag > max_q) begin
        max_q <= in_mag;
        idx_q <= pos_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_valid <= 1'b0;
      peak_idx  <= '0;
      ontime    <= '0;
      early     <= '0;
      late      <= '0;
      blk_done  <= 1'b0;
      blk_sum   <= '0;
      acc_q     <= '0;
      sym_cnt_q <= '0;
      long_q    <= 1'b0;
    end else begin
      sym_valid <= last;
      blk_done  <= last && blk_end;
      if (last) begin
        peak_idx <= pk_c;
        ontime   <= win_c[pk_c];
        early    <= win_c[e_idx];
        late     <= win_c[l_idx];
        long_q   <= long_c;
        if (blk_end) begin
          blk_sum   <= acc_q + SUM_W'(win_c[pk_c]);
          acc_q     <= '0;
          sym_cnt_q <= '0;
        end else begin
          acc_q     <= acc_q + SUM_W'(win_c[pk_c]);
          sym_cnt_q <= sym_cnt_q + 1'b1;
        end
      end
    end
  end

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);
  assert_ontime_peak_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (ontime >= early && ontime >= late));
  assert_peak_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (peak_idx < IDX_W'(SPS)));
  assert_short_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !long_q |-> (sym_cnt_q < CNT_W'(ACQ_SYMS)));
  assert_done_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> sym_valid);
  assert_acc_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (acc_q == '0));

endmodule

// File: tb/test_bitsync_sampler.sv
module test_bitsync_sampler;
  localparam int MAG_W = 12;
  localparam int SPS   = 22;

  typedef logic [MAG_W-1:0] win_t [SPS];

  logic        clk = 0, rst_n = 0, in_valid = 0, data_mode = 0;
  logic [11:0] in_mag = '0;
  logic        sym_valid, blk_done;
  logic [4:0]  peak_idx;
  logic [11:0] ontime, early, late;
  logic [17:0] blk_sum;

  int checks = 0, failures = 0;
  int m_cnt = 0, m_long = 0, m_acc = 0;

  bitsync_sampler i_bitsync_sampler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mag(in_mag),
    .data_mode(data_mode), .sym_valid(sym_valid), .peak_idx(peak_idx),
    .ontime(ontime), .early(early), .late(late), .blk_done(blk_done),
    .blk_sum(blk_sum));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int peak_of(input win_t w);
    int p = 0;
    for (int i = 1; i < SPS; i++) if (w[i] > w[p]) p = i;
    return p;
  endfunction

  task automatic run_symbol(input win_t w, input int gap_pct);
    int p, e, l, len;
    for (int i = 0; i < SPS; i++) begin
      while (int'($urandom_range(99)) < gap_pct) begin
        in_valid = 0;
        in_mag   = 12'hFFF;
        @(negedge clk);
      end
      in_valid = 1;
      in_mag   = w[i];
      @(negedge clk);
      if (i == 10) chk(sym_valid == 0, "R1 mid-window strobe", sym_valid, 0);
    end
    in_valid = 0;
    in_mag   = $urandom_range(4095);
    p = peak_of(w);
    e = (p == 0) ? SPS-1 : p-1;
    l = (p == SPS-1) ? 0 : p+1;
    chk(sym_valid == 1, "R1 strobe", sym_valid, 1);
    chk(int'(peak_idx) == p, "R2/R3 peak_idx", peak_idx, p);
    chk(ontime == w[p], "R2 ontime", ontime, w[p]);
    chk(early == w[e], "R4 early", early, w[e]);
    chk(late == w[l], "R4 late", late, w[l]);
    if (m_cnt == 0) m_long = data_mode;
    len = m_long ? 64 : 16;
    m_acc += w[p];
    m_cnt++;
    if (m_cnt == len) begin
      chk(blk_done == 1, "R6/R7 blk_done", blk_done, 1);
      chk(int'(blk_sum) == m_acc, "R7 blk_sum", blk_sum, m_acc);
      m_cnt = 0;
      m_acc = 0;
    end else begin
      chk(blk_done == 0, "R6/R7 no blk_done", blk_done, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    win_t w;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sym_valid == 0 && blk_done == 0, "R8 strobes after reset", sym_valid, 0);
    chk(ontime == 0 && early == 0 && late == 0 && peak_idx == 0, "R8 fields after reset", ontime, 0);
    chk(blk_sum == 0, "R8 blk_sum after reset", blk_sum, 0);

    for (int i = 0; i < SPS; i++) w[i] = 12'(i * 7);
    w[0] = 12'd4000;
    run_symbol(w, 0);                           // R4 wrap of early
    for (int i = 0; i < SPS; i++) w[i] = 12'(100 + i);
    w[21] = 12'd4095;
    run_symbol(w, 0);                           // R4 wrap of late
    for (int i = 0; i < SPS; i++) w[i] = 12'(i * 10);
    w[5] = 12'd3000; w[9] = 12'd3000;
    run_symbol(w, 0);                           // R3 tie
    for (int s = 0; s < 13; s++) begin
      for (int i = 0; i < SPS; i++) w[i] = 12'hFFF;
      run_symbol(w, 30);                        // R5 gaps, R7 full-scale sum
    end
    for (int s = 0; s < 16; s++) begin
      for (int i = 0; i < SPS; i++) w[i] = 12'hFFF;
      if (s == 8) data_mode = 1;                // R6 mid-block change
      run_symbol(w, 0);
    end
    for (int s = 0; s < 180; s++) begin
      if (s % 37 == 20) data_mode = ~data_mode;
      for (int i = 0; i < SPS; i++) w[i] = 12'($urandom_range(3000));
      if (s % 5 == 0) w[$urandom_range(SPS-1)] = w[$urandom_range(SPS-1)];
      run_symbol(w, 15);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule